// File: doc/BRIEF.md
# I2C Bus Hang Recovery Unit

This unit frees an I2C bus that a target device has left stuck, for example after a reset part-way through a byte while the target was driving a zero. Software issues a single recover command. The unit first samples both bus lines through a synchronizer. It then picks one of three paths.

- **Both lines high:** the bus is idle. The unit reports completion at once and never touches the lines.
- **SDA high but SCL held low:** the unit only generates a STOP sequence.
- **SDA held low:** the unit toggles SCL one pulse at a time. After each pulse it checks whether the target has let go of SDA. Once SDA is free it closes with a STOP.

Completion is reported as a one-cycle `recover_done` pulse. If SDA is still low after the largest allowed number of pulses, the unit gives up, releases both lines and reports a one-cycle `sda_timeout` pulse.

Phase lengths come from a prescaled `tick` supplied by the controller's timing generator. The open-drain pull-down drivers are shared with the master engine through a request/grant pair. While a recovery is running, the unit reports busy and blocks commands headed for the master engine. The caller decides when to start a recovery and what to do when it times out.

Top module: `i2c_unstick`

## Requirements
- R1: After reset, `busy`, `line_req`, `scl_pull`, `sda_pull`, `recover_done` and `sda_timeout` are all 0.
- R2: A recover command seen while both synchronized lines are high produces `recover_done` in the next cycle. In that case `line_req` and `busy` are never asserted and neither line is pulled.
- R3: No line is pulled until `line_grant` is high. While the grant is withheld, the unit waits with `busy` and `line_req` high and both pulls low.
- R4: With SDA held low, SCL is pulsed by alternating a pulled-low phase with a released phase, each ending on a `tick`. SDA is sampled at the end of each released phase. Pulsing stops after the first pulse that sees SDA high, so the count lies between 1 and MAX_PULSES (default 8).
- R5: After SDA is released, the unit ends with a STOP: SCL low, then SDA also low, then SCL released, then SDA released. `recover_done` is raised in the cycle SDA is released. SDA is never pulled while SCL is released, so no START condition is produced.
- R6: If SDA is still low at the end of pulse MAX_PULSES, the unit raises `sda_timeout` instead of `recover_done`, releases both lines, produces no STOP, and goes idle.
- R7: A command seen with SDA high and SCL held low produces no SCL pulses. The unit runs the STOP sequence, then raises `recover_done`.
- R8: `busy` is high from the cycle after an accepted command until the cycle `recover_done` or `sda_timeout` appears. While `busy` is high, `mst_cmd_out` is 0. While `busy` is low, `mst_cmd_out` follows `mst_cmd_in`.
- R9: A recover command issued while `busy` is high is ignored: the running sequence and its pulse count are unchanged.
- R10: `recover_done` and `sda_timeout` are each one cycle wide, and they are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Prescaled phase tick from the timing generator |
| recover_cmd | input | 1 | One-cycle recover command from software |
| scl_in | input | 1 | SCL line level (asynchronous) |
| sda_in | input | 1 | SDA line level (asynchronous) |
| line_grant | input | 1 | Grant of the shared line drivers |
| mst_cmd_in | input | 1 | Command headed for the master engine |
| line_req | output | 1 | Request for the shared line drivers |
| scl_pull | output | 1 | 1 pulls SCL low |
| sda_pull | output | 1 | 1 pulls SDA low |
| busy | output | 1 | Recovery in progress |
| recover_done | output | 1 | One-cycle completion pulse |
| sda_timeout | output | 1 | One-cycle pulse: SDA stayed low after the last pulse |
| mst_cmd_out | output | 1 | Master command passed on, blocked while busy |

## Verification
A wrong sequencer state shows up on the bus lines within one tick period:

- An extra or missing SCL rise.
- An SDA fall while SCL is high, which looks like a spurious START.
- A missing final SDA rise with SCL high, which means no STOP.

A miscount in the pulse counter shows up as the wrong number of SCL rises before `recover_done`, or as a timeout that comes early or late. A broken busy flag shows within a cycle as a master command leaking through, or as a second recover command restarting the count.

// File: rtl/i2c_unstick_pkg.sv
package i2c_unstick_pkg;

    typedef enum logic [2:0] {
        RS_IDLE,
        RS_WAIT_GNT,
        RS_SCL_LO,
        RS_SCL_HI,
        RS_STOP_A,
        RS_STOP_B,
        RS_STOP_C
    } rs_state_e;

    typedef struct packed {
        rs_state_e st;
        logic      via_pulse;
        logic      done;
        logic      tmo;
    } rs_regs_t;

endpackage

// File: rtl/i2c_unstick_sync.sv
module i2c_unstick_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[g] <= '1;
                end else if (g == 0) begin
                    stage_q[g] <= async_in;
                end else begin
                    stage_q[g] <= stage_q[(g > 0) ? g-1 : 0];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/i2c_unstick_cnt.sv
module i2c_unstick_cnt #(
    parameter int MAX_PULSES = 8,
    localparam int CW = $clog2(MAX_PULSES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == CW'(MAX_PULSES - 1));
endmodule

// File: rtl/i2c_unstick_seq.sv
module i2c_unstick_seq
    import i2c_unstick_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic go,
    input  logic scl_s,
    input  logic sda_s,
    input  logic grant,
    input  logic cnt_last,
    output logic cnt_inc,
    output logic cnt_clr,
    output logic req,
    output logic scl_pull,
    output logic sda_pull,
    output logic busy,
    output logic done,
    output logic tmo
);
    rs_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.tmo  = 1'b0;
        cnt_inc  = 1'b0;
        unique case (r_q.st)
            RS_IDLE: begin
                if (go) begin
                    if (sda_s && scl_s) begin
                        r_d.done = 1'b1;
                    end else begin
                        r_d.st        = RS_WAIT_GNT;
                        r_d.via_pulse = !sda_s;
                    end
                end
            end
            RS_WAIT_GNT: begin
                if (grant) r_d.st = r_q.via_pulse ? RS_SCL_LO : RS_STOP_A;
            end
            RS_SCL_LO: begin
                if (tick) r_d.st = RS_SCL_HI;
            end
            RS_SCL_HI: begin
                if (tick) begin
                    if (sda_s) begin
                        r_d.st = RS_STOP_A;
                    end else if (cnt_last) begin
                        r_d.st  = RS_IDLE;
                        r_d.tmo = 1'b1;
                    end else begin
                        r_d.st  = RS_SCL_LO;
                        cnt_inc = 1'b1;
                    end
                end
            end
            RS_STOP_A: begin
                if (tick) r_d.st = RS_STOP_B;
            end
            RS_STOP_B: begin
                if (tick) r_d.st = RS_STOP_C;
            end
            RS_STOP_C: begin
                if (tick) begin
                    r_d.st   = RS_IDLE;
                    r_d.done = 1'b1;
                end
            end
            default: r_d.st = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: RS_IDLE, via_pulse: 1'b0, done: 1'b0, tmo: 1'b0};
        else        r_q <= r_d;
    end

    assign busy     = (r_q.st != RS_IDLE);
    assign req      = busy;
    assign cnt_clr  = !busy;
    assign scl_pull = (r_q.st == RS_SCL_LO) || (r_q.st == RS_STOP_A) || (r_q.st == RS_STOP_B);
    assign sda_pull = (r_q.st == RS_STOP_B) || (r_q.st == RS_STOP_C);
    assign done     = r_q.done;
    assign tmo      = r_q.tmo;
endmodule

// File: rtl/i2c_unstick.sv
module i2c_unstick #(
    parameter int MAX_PULSES  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic recover_cmd,
    input  logic scl_in,
    input  logic sda_in,
    input  logic line_grant,
    input  logic mst_cmd_in,
    output logic line_req,
    output logic scl_pull,
    output logic sda_pull,
    output logic busy,
    output logic recover_done,
    output logic sda_timeout,
    output logic mst_cmd_out
);
    logic [1:0] lines_s;
    logic       cnt_inc, cnt_clr, cnt_last;

    i2c_unstick_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({scl_in, sda_in}),
        .sync_out (lines_s)
    );

    i2c_unstick_cnt #(.MAX_PULSES(MAX_PULSES)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .last  (cnt_last)
    );

    i2c_unstick_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .go       (recover_cmd),
        .scl_s    (lines_s[1]),
        .sda_s    (lines_s[0]),
        .grant    (line_grant),
        .cnt_last (cnt_last),
        .cnt_inc  (cnt_inc),
        .cnt_clr  (cnt_clr),
        .req      (line_req),
        .scl_pull (scl_pull),
        .sda_pull (sda_pull),
        .busy     (busy),
        .done     (recover_done),
        .tmo      (sda_timeout)
    );

    assign mst_cmd_out = mst_cmd_in && !busy;
endmodule

// File: rtl/i2c_unstick_chk.sv
module i2c_unstick_chk #(
    parameter int MAX_PULSES = 8
) (
    input logic clk,
    input logic rst_n,
    input logic line_req,
    input logic line_grant,
    input logic scl_pull,
    input logic sda_pull,
    input logic busy,
    input logic recover_done,
    input logic sda_timeout,
    input logic mst_cmd_out
);
    int unsigned pull_rises;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      pull_rises <= 0;
        else if (!busy)                  pull_rises <= 0;
        else if (scl_pull && !$past(scl_pull)) pull_rises <= pull_rises + 1;
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_pull && !sda_pull && !line_req));

    assert_pull_needs_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_pull || sda_pull) |-> (line_req && line_grant));

    assert_pulse_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pull_rises <= MAX_PULSES + 1);

    assert_no_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> scl_pull);

    assert_timeout_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sda_timeout |-> (!busy && !scl_pull && !sda_pull));

    assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !mst_cmd_out);

    assert_done_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
        recover_done |=> !recover_done);

    assert_tmo_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sda_timeout |=> !sda_timeout);

    assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(recover_done && sda_timeout));
endmodule

bind i2c_unstick i2c_unstick_chk #(.MAX_PULSES(MAX_PULSES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_req     (line_req),
    .line_grant   (line_grant),
    .scl_pull     (scl_pull),
    .sda_pull     (sda_pull),
    .busy         (busy),
    .recover_done (recover_done),
    .sda_timeout  (sda_timeout),
    .mst_cmd_out  (mst_cmd_out)
);

// File: tb/tb_i2c_unstick.sv
`timescale 1ns/1ps
module tb_i2c_unstick;
    localparam int TDIV = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic recover_cmd = 1'b0;
    logic mst_cmd_in = 1'b0;
    logic gnt_allow = 1'b1;
    logic ext_scl_low = 1'b0;
    logic slave_arm = 1'b0;
    int   slave_k = 1;
    logic line_req, scl_pull, sda_pull, busy, recover_done, sda_timeout, mst_cmd_out;
    logic line_grant, scl_line, sda_line;

    int vectors = 0;
    int errors  = 0;

    always #2.5 clk = ~clk;

    assign line_grant = line_req && gnt_allow;

    logic slave_low = 1'b0;
    int   falls_seen = 0;
    assign scl_line = !(scl_pull || ext_scl_low);
    assign sda_line = !(sda_pull || slave_low);

    i2c_unstick dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .recover_cmd(recover_cmd),
        .scl_in(scl_line), .sda_in(sda_line), .line_grant(line_grant),
        .mst_cmd_in(mst_cmd_in), .line_req(line_req), .scl_pull(scl_pull),
        .sda_pull(sda_pull), .busy(busy), .recover_done(recover_done),
        .sda_timeout(sda_timeout), .mst_cmd_out(mst_cmd_out)
    );

    int tick_cnt = 0;
    always @(posedge clk) begin
        tick_cnt <= (tick_cnt == TDIV-1) ? 0 : tick_cnt + 1;
        tick     <= (tick_cnt == TDIV-1);
    end

    // Target model: holds SDA low until the k-th falling edge of SCL.
    logic prev_scl = 1'b1, prev_sda = 1'b1, prev_sdap = 1'b0;
    int scl_rises = 0, starts = 0, stops = 0, done_cycles = 0, tmo_cycles = 0, sdap_rises = 0;
    always @(posedge clk) begin
        prev_scl  <= scl_line;
        prev_sda  <= sda_line;
        prev_sdap <= sda_pull;
        if (slave_arm) begin
            slave_low  <= 1'b1;
            falls_seen <= 0;
        end else if (slave_low && prev_scl && !scl_line) begin
            falls_seen <= falls_seen + 1;
            if (falls_seen + 1 >= slave_k) slave_low <= 1'b0;
        end
        if (scl_line && !prev_scl) scl_rises <= scl_rises + 1;
        if (scl_line && prev_scl && prev_sda && !sda_line) starts <= starts + 1;
        if (scl_line && prev_scl && !prev_sda && sda_line) stops <= stops + 1;
        if (sda_pull && !prev_sdap) sdap_rises <= sdap_rises + 1;
        if (recover_done) done_cycles <= done_cycles + 1;
        if (sda_timeout)  tmo_cycles  <= tmo_cycles + 1;
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic pulse_cmd();
        @(negedge clk) recover_cmd = 1'b1;
        @(negedge clk) recover_cmd = 1'b0;
    endtask

    task automatic test_reset();
        chk(busy == 0, "R1 busy", busy, 0);
        chk(line_req == 0, "R1 line_req", line_req, 0);
        chk({scl_pull, sda_pull} == 0, "R1 pulls", {scl_pull, sda_pull}, 0);
        chk({recover_done, sda_timeout} == 0, "R1 status", {recover_done, sda_timeout}, 0);
    endtask

    task automatic test_idle_bus();
        int d0 = done_cycles;
        @(negedge clk) recover_cmd = 1'b1;
        @(negedge clk) recover_cmd = 1'b0;
        chk(recover_done == 1, "R2 done next cycle", recover_done, 1);
        chk(busy == 0 && line_req == 0, "R2 no request", {busy, line_req}, 0);
        @(negedge clk);
        chk(recover_done == 0, "R10 done one cycle", recover_done, 0);
        chk(done_cycles - d0 == 1, "R2 done count", done_cycles - d0, 1);
    endtask

    // Runs one recovery with the target releasing at its k-th SCL fall.
    task automatic run_case(input string tag, input int k, input bit withhold,
                            input bit retrigger, input bit exp_done, input int exp_pulses);
        int r0, st0, sp0, d0, t0;
        bit fin = 0;
        slave_k = k;
        @(negedge clk) slave_arm = 1'b1;
        @(negedge clk) slave_arm = 1'b0;
        repeat (4) @(negedge clk);
        r0 = scl_rises; st0 = starts; sp0 = stops; d0 = done_cycles; t0 = tmo_cycles;
        gnt_allow = !withhold;
        pulse_cmd();
        if (withhold) begin
            repeat (20) @(negedge clk);
            chk(busy && line_req && !scl_pull && !sda_pull, {tag, " R3 wait for grant"},
                {busy, line_req, scl_pull, sda_pull}, 4'b1100);
            chk(scl_rises == r0, {tag, " R3 no edges"}, scl_rises - r0, 0);
            gnt_allow = 1'b1;
        end
        repeat (3) @(negedge clk);
        mst_cmd_in = 1'b1;
        #0.1;
        chk(busy && !mst_cmd_out, {tag, " R8 master blocked"}, mst_cmd_out, 0);
        mst_cmd_in = 1'b0;
        if (retrigger) pulse_cmd();
        for (int i = 0; i < 2000 && !fin; i++) begin
            @(negedge clk);
            if (recover_done || sda_timeout) fin = 1;
        end
        chk(fin, {tag, " R8 finished"}, fin, 1);
        chk(busy == 0, {tag, " R8 busy drops with status"}, busy, 0);
        repeat (4) @(negedge clk);
        if (exp_done) begin
            chk(done_cycles - d0 == 1 && tmo_cycles == t0, {tag, " R4 done once"},
                done_cycles - d0, 1);
            chk(scl_rises - r0 == exp_pulses + 1, {tag, " R4 pulse count"},
                scl_rises - r0 - 1, exp_pulses);
            chk(stops - sp0 == 1, {tag, " R5 one STOP"}, stops - sp0, 1);
        end else begin
            chk(tmo_cycles - t0 == 1 && done_cycles == d0, {tag, " R6 timeout once"},
                tmo_cycles - t0, 1);
            chk(scl_rises - r0 == exp_pulses, {tag, " R6 pulse count"}, scl_rises - r0, exp_pulses);
            chk(stops == sp0, {tag, " R6 no STOP"}, stops - sp0, 0);
            chk(scl_line == 1, {tag, " R6 SCL released"}, scl_line, 1);
        end
        chk(starts == st0, {tag, " R5 no START"}, starts - st0, 0);
        mst_cmd_in = 1'b1;
        #0.1;
        chk(mst_cmd_out == 1, {tag, " R8 master passes when idle"}, mst_cmd_out, 1);
        mst_cmd_in = 1'b0;
        @(negedge clk) slave_k = 1;
    endtask

    task automatic test_scl_stuck();
        int r0, d0, a0;
        bit fin = 0;
        repeat (2) @(negedge clk);
        ext_scl_low = 1'b1;
        repeat (4) @(negedge clk);
        r0 = scl_rises; d0 = done_cycles; a0 = sdap_rises;
        pulse_cmd();
        for (int i = 0; i < 500 && !fin; i++) begin
            @(negedge clk);
            if (recover_done || sda_timeout) fin = 1;
        end
        chk(fin && recover_done, "R7 done reported", recover_done, 1);
        chk(scl_rises == r0, "R7 no SCL pulses", scl_rises - r0, 0);
        chk(sdap_rises - a0 == 1, "R7 STOP attempted", sdap_rises - a0, 1);
        ext_scl_low = 1'b0;
        repeat (4) @(negedge clk);
        chk(scl_line && sda_line, "R7 lines released", {scl_line, sda_line}, 3);
        chk(done_cycles - d0 == 1, "R10 single done", done_cycles - d0, 1);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        test_reset();
        test_idle_bus();
        run_case("k1", 1, 0, 0, 1, 1);
        run_case("k3", 3, 0, 0, 1, 3);
        run_case("k8", 8, 0, 0, 1, 8);
        run_case("grant", 2, 1, 0, 1, 2);
        run_case("R9 retrigger", 4, 0, 1, 1, 4);
        run_case("never", 99, 0, 0, 0, 8);
        test_scl_stuck();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule